// File: doc/BRIEF.md
# Addressed serial control register

This block takes 23-bit control words from a slow three-wire port: a serial clock, a serial data line and a load strobe. While the strobe is low, each rising edge of the serial clock pushes one data bit into a shift register. The first bit sent becomes the most significant. The rising edge of the strobe copies the collected word into one of two holding banks. The last bit of the word chooses the bank.

The divider bank holds three fields: a 13-bit main count, a 5-bit swallow count and a 2-bit charge-pump enable pair. The reference bank holds a 13-bit reference count and a 2-bit monitor test code. Each field sits at a fixed place in the word. Some bits are ignored in one layout but used in the other.

All three pins are sampled by the system clock. They pass through a synchronizer, and edges are found after it. Words are still accepted and latched while the power-save input is high. During power-save the pump drive outputs are forced off, but the stored selection is kept.

Top module: `sctl_reg`

## Requirements
- R1: During and after reset, with the strobe idle high, `div_m`=324, `div_s`=4, `ref_r`=1280, `test_sel`=2'b01, `pump_sel`=2'b00 and `pump_drive`=2'b00.
- R2: A word whose last bit is 1 loads the divider bank:
  - Bits are numbered D22 (sent first) down to D1, with the address bit sent last.
  - `div_m` takes D1 as MSB through D13 as LSB.
  - `div_s` takes D14 as MSB through D18 as LSB.
  - `pump_sel[1]` takes D22 and `pump_sel[0]` takes D21.
  - `ref_r` and `test_sel` keep their values.
- R3: A word whose last bit is 0 loads the reference bank:
  - `ref_r` takes D10 as MSB through D22 as LSB.
  - `test_sel[1]` takes D9 and `test_sel[0]` takes D8.
  - `div_m`, `div_s` and `pump_sel` keep their values.
- R4: D19 and D20 have no effect on a divider-bank load, and D1 to D7 have no effect on a reference-bank load.
- R5: Serial clock edges and data seen while the strobe is high do not change the shift register. A strobe low-high pulse with no clocks between re-latches the word shifted before.
- R6: No output field changes while bits are being shifted. Fields change only after a rising edge of the strobe.
- R7: When more than 23 bits are shifted before the strobe rises, only the last 23 bits decide the load.
- R8: `pump_drive` equals `pump_sel` one system clock later while `psave` is low, and is 2'b00 one clock after `psave` is high. Words sent during power-save are still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock pin (asynchronous) |
| ser_data | input | 1 | Serial data pin (asynchronous) |
| ser_le | input | 1 | Load strobe pin, low while shifting (asynchronous) |
| psave | input | 1 | Power-save request |
| div_m | output | 13 | Main count field |
| div_s | output | 5 | Swallow count field |
| pump_sel | output | 2 | Stored pump enable pair {internal, external} |
| pump_drive | output | 2 | Pump enables after power-save masking |
| ref_r | output | 13 | Reference count field |
| test_sel | output | 2 | Monitor test code |

## Verification
Pin changes reach the edge detector after SYNC_STAGES system clocks. A strobe rise therefore updates the field outputs SYNC_STAGES+1 clocks after the pin moves, and `pump_drive` follows one clock after that. The bench holds every serial pin level for four system clocks. It samples the fields ten clocks after the strobe rises, and samples `pump_drive` several clocks after a `psave` change, so every result is already due. Field stability during shifting is checked after the last bit and before the strobe rises.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   // bank address carried by the last bit of a word
   typedef enum logic {
      ADDR_REF = 1'b0,
      ADDR_DIV = 1'b1
   } sctl_addr_e;

   // idle pin levels used as synchronizer reset values
   localparam logic LE_IDLE  = 1'b1;
   localparam logic CLK_IDLE = 1'b0;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES < 2) begin : g_bad_depth
      $error("sctl_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int WORD_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] sr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sr <= '0;
      else if (shift_en) sr <= {sr[WORD_W-2:0], bit_in};
   end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank import sctl_pkg::*; #(
   parameter int M_W = 13,
   parameter int S_W = 5,
   parameter int PUMP_W = 2,
   parameter int R_W = 13,
   parameter int TST_W = 2,
   parameter int A0_GAP_W = 7,
   parameter int WORD_W = 23,
   parameter int unsigned DEF_M = 324,
   parameter int unsigned DEF_S = 4,
   parameter int unsigned DEF_R = 1280,
   parameter int unsigned DEF_TST = 1,
   parameter int unsigned DEF_PUMP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [M_W-1:0]    div_m,
   output logic [S_W-1:0]    div_s,
   output logic [PUMP_W-1:0] pump_sel,
   output logic [R_W-1:0]    ref_r,
   output logic [TST_W-1:0]  test_sel
);
   localparam int TST_TOP = A0_GAP_W + TST_W;

   sctl_addr_e        addr;
   logic [M_W-1:0]    m_nxt;
   logic [S_W-1:0]    s_nxt;
   logic [PUMP_W-1:0] pump_nxt;
   logic [R_W-1:0]    r_nxt;
   logic [TST_W-1:0]  tst_nxt;

   assign addr = sctl_addr_e'(word[0]);

   // word[k] holds Dk; counts arrive MSB at the lower D index
   for (genvar i = 0; i < M_W; i++) begin : g_m
      assign m_nxt[i] = word[M_W - i];
   end
   for (genvar i = 0; i < S_W; i++) begin : g_s
      assign s_nxt[i] = word[M_W + S_W - i];
   end
   for (genvar i = 0; i < R_W; i++) begin : g_r
      assign r_nxt[i] = word[WORD_W - 1 - i];
   end
   assign pump_nxt = word[WORD_W-1 -: PUMP_W];
   assign tst_nxt  = word[TST_TOP -: TST_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_m    <= M_W'(DEF_M);
         div_s    <= S_W'(DEF_S);
         pump_sel <= PUMP_W'(DEF_PUMP);
      end else if (load && addr == ADDR_DIV) begin
         div_m    <= m_nxt;
         div_s    <= s_nxt;
         pump_sel <= pump_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_r    <= R_W'(DEF_R);
         test_sel <= TST_W'(DEF_TST);
      end else if (load && addr == ADDR_REF) begin
         ref_r    <= r_nxt;
         test_sel <= tst_nxt;
      end
   end
endmodule

// File: rtl/sctl_reg.sv
module sctl_reg import sctl_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter int M_W = 13,
   parameter int S_W = 5,
   parameter int A1_GAP_W = 2,
   parameter int PUMP_W = 2,
   parameter int R_W = 13,
   parameter int TST_W = 2,
   parameter int A0_GAP_W = 7,
   parameter int unsigned DEF_M = 324,
   parameter int unsigned DEF_S = 4,
   parameter int unsigned DEF_R = 1280,
   parameter int unsigned DEF_TST = 1,
   parameter int unsigned DEF_PUMP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   input  logic              psave,
   output logic [M_W-1:0]    div_m,
   output logic [S_W-1:0]    div_s,
   output logic [PUMP_W-1:0] pump_sel,
   output logic [PUMP_W-1:0] pump_drive,
   output logic [R_W-1:0]    ref_r,
   output logic [TST_W-1:0]  test_sel
);
   localparam int WORD_W = 1 + M_W + S_W + A1_GAP_W + PUMP_W;
   localparam int A0_SUM = 1 + A0_GAP_W + TST_W + R_W;

   if (A0_SUM != WORD_W) begin : g_bad_layout
      $error("sctl_reg: reference layout width differs from divider layout");
   end
   if (DEF_M >= (1 << M_W) || DEF_S >= (1 << S_W) || DEF_R >= (1 << R_W)) begin : g_bad_def
      $error("sctl_reg: a default count does not fit its field");
   end

   logic [2:0]        pins_s;
   logic              ck_s, dt_s, le_s;
   logic              ck_d, le_d;
   logic              ck_rise, le_rise, shift_en;
   logic [WORD_W-1:0] sr;

   sctl_sync #(
      .W(3), .STAGES(SYNC_STAGES), .RST_VAL({LE_IDLE, 1'b0, CLK_IDLE})
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ser_le, ser_data, ser_clk}), .q(pins_s)
   );

   assign {le_s, dt_s, ck_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_d <= CLK_IDLE;
         le_d <= LE_IDLE;
      end else begin
         ck_d <= ck_s;
         le_d <= le_s;
      end
   end

   assign ck_rise  = ck_s & ~ck_d;
   assign le_rise  = le_s & ~le_d;
   assign shift_en = ck_rise & ~le_s;

   sctl_shift #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(dt_s), .sr(sr)
   );

   sctl_bank #(
      .M_W(M_W), .S_W(S_W), .PUMP_W(PUMP_W), .R_W(R_W), .TST_W(TST_W),
      .A0_GAP_W(A0_GAP_W), .WORD_W(WORD_W), .DEF_M(DEF_M), .DEF_S(DEF_S),
      .DEF_R(DEF_R), .DEF_TST(DEF_TST), .DEF_PUMP(DEF_PUMP)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .load(le_rise), .word(sr),
      .div_m(div_m), .div_s(div_s), .pump_sel(pump_sel),
      .ref_r(ref_r), .test_sel(test_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pump_drive <= '0;
      else if (psave) pump_drive <= '0;
      else            pump_drive <= pump_sel;
   end
endmodule

// File: rtl/sctl_reg_chk.sv
module sctl_reg_chk #(
   parameter int M_W = 13,
   parameter int S_W = 5,
   parameter int PUMP_W = 2,
   parameter int R_W = 13,
   parameter int TST_W = 2,
   parameter int WORD_W = 23,
   parameter int unsigned DEF_M = 324,
   parameter int unsigned DEF_S = 4,
   parameter int unsigned DEF_R = 1280
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psave,
   input logic              le_s,
   input logic              le_rise,
   input logic [WORD_W-1:0] sr,
   input logic [M_W-1:0]    div_m,
   input logic [S_W-1:0]    div_s,
   input logic [PUMP_W-1:0] pump_sel,
   input logic [PUMP_W-1:0] pump_drive,
   input logic [R_W-1:0]    ref_r,
   input logic [TST_W-1:0]  test_sel
);
   AST_RESET_DEFAULTS: assert property (@(posedge clk)
      $rose(rst_n) |-> (div_m == M_W'(DEF_M) && div_s == S_W'(DEF_S) && ref_r == R_W'(DEF_R))); // R1

   AST_ONE_BANK_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise |=> !(!$stable(div_m) && !$stable(ref_r))); // R2

   AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      le_s |=> $stable(sr)); // R5

   AST_FIELDS_NEED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> ($stable(div_m) && $stable(div_s) && $stable(ref_r)
                    && $stable(test_sel) && $stable(pump_sel))); // R6

   AST_PSAVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      psave |=> pump_drive == '0); // R8

   AST_PUMP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !psave |=> pump_drive == $past(pump_sel)); // R8
endmodule

bind sctl_reg sctl_reg_chk #(
   .M_W(M_W), .S_W(S_W), .PUMP_W(PUMP_W), .R_W(R_W), .TST_W(TST_W),
   .WORD_W(WORD_W), .DEF_M(DEF_M), .DEF_S(DEF_S), .DEF_R(DEF_R)
) u_chk (
   .clk(clk), .rst_n(rst_n), .psave(psave), .le_s(le_s), .le_rise(le_rise),
   .sr(sr), .div_m(div_m), .div_s(div_s), .pump_sel(pump_sel),
   .pump_drive(pump_drive), .ref_r(ref_r), .test_sel(test_sel)
);

// File: tb/sctl_reg_test.sv
module sctl_reg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_le = 1'b1;
   logic        psave = 1'b0;
   logic [12:0] div_m;
   logic [4:0]  div_s;
   logic [1:0]  pump_sel;
   logic [1:0]  pump_drive;
   logic [12:0] ref_r;
   logic [1:0]  test_sel;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sctl_reg uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .psave(psave), .div_m(div_m), .div_s(div_s),
      .pump_sel(pump_sel), .pump_drive(pump_drive), .ref_r(ref_r),
      .test_sel(test_sel)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #2;
   endtask

   // word[k] = Dk for k=1..22, word[0] = address bit
   function automatic logic [22:0] word_div(input int m, input int s,
                                            input logic [1:0] pump,
                                            input logic [1:0] gap);
      logic [22:0] w = '0;
      for (int i = 0; i < 13; i++) w[13-i] = m[i];
      for (int i = 0; i < 5; i++)  w[18-i] = s[i];
      w[19] = gap[0];
      w[20] = gap[1];
      w[21] = pump[0];
      w[22] = pump[1];
      w[0]  = 1'b1;
      return w;
   endfunction

   function automatic logic [22:0] word_ref(input int r, input logic [1:0] tst,
                                            input logic [6:0] junk);
      logic [22:0] w = '0;
      for (int i = 0; i < 13; i++) w[22-i] = r[i];
      w[9] = tst[1];
      w[8] = tst[0];
      w[7:1] = junk;
      w[0] = 1'b0;
      return w;
   endfunction

   task automatic clock_bit(input logic b);
      ser_data = b;
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
   endtask

   task automatic shift_word(input logic [22:0] w);
      ser_le = 1'b0;
      wait_cyc(4);
      for (int k = 22; k >= 0; k--) clock_bit(w[k]);
      wait_cyc(6);
   endtask

   task automatic strobe();
      ser_le = 1'b1;
      wait_cyc(10);
   endtask

   task automatic t_reset();
      check("R1 div_m", int'(div_m), 324);
      check("R1 div_s", int'(div_s), 4);
      check("R1 ref_r", int'(ref_r), 1280);
      check("R1 test_sel", int'(test_sel), 1);
      check("R1 pump_sel", int'(pump_sel), 0);
      check("R1 pump_drive", int'(pump_drive), 0);
   endtask

   task automatic t_div_load();
      shift_word(word_div(5000, 17, 2'b10, 2'b11));
      check("R6 div_m before strobe", int'(div_m), 324);
      check("R6 div_s before strobe", int'(div_s), 4);
      strobe();
      check("R2 div_m", int'(div_m), 5000);
      check("R2 div_s", int'(div_s), 17);
      check("R2 pump_sel", int'(pump_sel), 2);
      check("R2 ref_r kept", int'(ref_r), 1280);
      check("R2 test_sel kept", int'(test_sel), 1);
      check("R8 pump_drive follows", int'(pump_drive), 2);
   endtask

   task automatic t_ref_load();
      shift_word(word_ref(2, 2'b10, 7'h7F));
      check("R6 ref_r before strobe", int'(ref_r), 1280);
      strobe();
      check("R3 ref_r", int'(ref_r), 2);
      check("R3 test_sel", int'(test_sel), 2);
      check("R3 div_m kept", int'(div_m), 5000);
      check("R3 pump_sel kept", int'(pump_sel), 2);
      shift_word(word_ref(4097, 2'b01, 7'h00));
      strobe();
      check("R4 ref_r junk-free", int'(ref_r), 4097);
      check("R4 test_sel", int'(test_sel), 1);
   endtask

   task automatic t_gap_bits();
      shift_word(word_div(77, 9, 2'b01, 2'b00));
      strobe();
      check("R4 div_m gap 00", int'(div_m), 77);
      shift_word(word_div(77, 9, 2'b01, 2'b11));
      strobe();
      check("R4 div_m gap 11", int'(div_m), 77);
      check("R4 div_s gap 11", int'(div_s), 9);
      check("R4 ref_r kept", int'(ref_r), 4097);
   endtask

   task automatic t_le_high();
      for (int k = 0; k < 23; k++) clock_bit(1'b1);
      wait_cyc(6);
      ser_le = 1'b0;
      wait_cyc(8);
      strobe();
      check("R5 div_m", int'(div_m), 77);
      check("R5 div_s", int'(div_s), 9);
      check("R5 ref_r", int'(ref_r), 4097);
   endtask

   task automatic t_overlong();
      ser_le = 1'b0;
      wait_cyc(4);
      clock_bit(1'b0);
      clock_bit(1'b1);
      clock_bit(1'b0);
      shift_word(word_div(32, 0, 2'b01, 2'b00));
      strobe();
      check("R7 div_m", int'(div_m), 32);
      check("R7 div_s", int'(div_s), 0);
      check("R7 pump_sel", int'(pump_sel), 1);
   endtask

   task automatic t_psave();
      psave = 1'b1;
      wait_cyc(3);
      check("R8 drive off", int'(pump_drive), 0);
      shift_word(word_div(8191, 31, 2'b11, 2'b00));
      strobe();
      check("R8 div_m in psave", int'(div_m), 8191);
      check("R8 div_s in psave", int'(div_s), 31);
      check("R8 pump_sel in psave", int'(pump_sel), 3);
      check("R8 drive still off", int'(pump_drive), 0);
      psave = 1'b0;
      wait_cyc(3);
      check("R8 drive back", int'(pump_drive), 3);
   endtask

   initial begin
      wait_cyc(3);
      t_reset();
      rst_n = 1'b1;
      wait_cyc(5);
      t_reset();
      t_div_load();
      t_ref_load();
      t_gap_bits();
      t_le_high();
      t_overlong();
      t_psave();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule